// File: doc/BRIEF.md
# Vectored Interrupt Request/Service Tracker

This block keeps the interrupt bookkeeping for a single processor core. It holds two bit-vectors with one bit for each interrupt vector. The request set records interrupts that have been accepted and are waiting. The service set records interrupts that the core has taken and not yet retired. The vector number is also the priority, so a larger number always wins.

The surrounding logic delivers accepted interrupts as a strobe with a vector number. The core answers the pending line with an acknowledge, and it retires work with an end-of-interrupt strobe. An end-of-interrupt carries no vector. It always retires the highest in-service bit. A surplus end-of-interrupt can therefore retire a nested interrupt that was never handled, and the block keeps this behaviour on purpose. Both sets are visible at the ports for observation.

Top module: `vit_tracker`

## Requirements
- R1: When `acc_vld` is high, the request bit indexed by `acc_vec` is set at the next rising edge.
- R2: Accepting a vector whose request bit is already set leaves the request set unchanged (the two requests merge).
- R3: When `ack` is high and a request bit is set, the highest set request bit is cleared and the same bit is set in the service set in one edge. When `ack` is high and the request set is empty, the request set and the service set stay unchanged.
- R4: `disp_vec` equals the index of the highest set service bit, and it is 0 when the service set is empty.
- R5: An accept and a transfer in the same cycle both take effect. If both touch the same vector, that vector ends up both in service and still pending.
- R6: When `eoi` is high and the service set is not empty, only the highest set service bit is cleared. No vector argument is taken into account.
- R7: When `eoi` retires a bit and a request is pending, the highest pending request is moved into service at the same edge. When `ack` and `eoi` are high together, only one request is moved.
- R8: A second end-of-interrupt for one handled interrupt retires the nested interrupt that was moved into service by the first one. That interrupt is then gone from both sets.
- R9: `eoi` with an empty service set changes neither set.
- R10: `int_pend` is high exactly when the request set is not empty and either the service set is empty or bits [7:4] of the highest request index are greater than bits [7:4] of the highest service index.
- R11: While `rst_n` is low at a rising edge, both sets are cleared, so `int_pend` is 0 and `disp_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | Accept strobe for a new interrupt |
| acc_vec | input | 8 | Vector number being accepted |
| ack | input | 1 | Core is ready to take the next interrupt |
| eoi | input | 1 | End-of-interrupt strobe |
| disp_vec | output | 8 | Highest vector currently in service |
| int_pend | output | 1 | Interrupt pending toward the core |
| irr_o | output | 256 | Request set contents |
| isr_o | output | 256 | Service set contents |

## Verification
The accept path and the transfer path can hit the same cycle and even the same vector. The bench drives an accept together with an acknowledge, or together with an end-of-interrupt, and sometimes reuses the vector that is about to be moved. It judges the outcome against a behavioural model that updates both sets and compares every output on every clock. A directed double end-of-interrupt sequence checks that a nested vector vanishes from both sets. Class-boundary cases check the pending rule on the upper nibble.

// File: rtl/vit_pkg.sv
package vit_pkg;
    parameter int VIT_NUM_VEC   = 256;
    parameter int VIT_CLASS_W   = 4;
endpackage

// File: rtl/vit_top_find.sv
// Finds the highest set bit of a vector; higher index means higher priority.
module vit_top_find #(
    parameter int N = 256,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic [W-1:0] idx_o,
    output logic         any_o
);
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                idx_o = W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vit_pend_cmp.sv
// Decides whether the best waiting request outranks the current service class.
module vit_pend_cmp #(
    parameter int W       = 8,
    parameter int CLASS_W = 4
) (
    input  logic         req_any_i,
    input  logic [W-1:0] req_idx_i,
    input  logic         svc_any_i,
    input  logic [W-1:0] svc_idx_i,
    output logic         pend_o
);
    localparam int LO = W - CLASS_W;

    logic [CLASS_W-1:0] req_cls, svc_cls;

    always_comb begin
        req_cls = req_idx_i[W-1:LO];
        svc_cls = svc_idx_i[W-1:LO];
        pend_o  = req_any_i && (!svc_any_i || (req_cls > svc_cls));
    end
endmodule

// File: rtl/vit_tracker.sv
module vit_tracker #(
    parameter int NUM_VEC = vit_pkg::VIT_NUM_VEC,
    parameter int CLASS_W = vit_pkg::VIT_CLASS_W,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_vld,
    input  logic [VEC_W-1:0]   acc_vec,
    input  logic               ack,
    input  logic               eoi,
    output logic [VEC_W-1:0]   disp_vec,
    output logic               int_pend,
    output logic [NUM_VEC-1:0] irr_o,
    output logic [NUM_VEC-1:0] isr_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] req;
        logic [NUM_VEC-1:0] svc;
    } trk_state_t;

    trk_state_t st_q, st_d;

    logic [VEC_W-1:0] req_top, svc_top;
    logic             req_any, svc_any;
    logic             retire, xfer;

    vit_top_find #(.N(NUM_VEC), .W(VEC_W)) u_req_find (
        .bits_i(st_q.req), .idx_o(req_top), .any_o(req_any)
    );

    vit_top_find #(.N(NUM_VEC), .W(VEC_W)) u_svc_find (
        .bits_i(st_q.svc), .idx_o(svc_top), .any_o(svc_any)
    );

    vit_pend_cmp #(.W(VEC_W), .CLASS_W(CLASS_W)) u_pend (
        .req_any_i(req_any), .req_idx_i(req_top),
        .svc_any_i(svc_any), .svc_idx_i(svc_top),
        .pend_o(int_pend)
    );

    always_comb begin
        st_d   = st_q;
        retire = eoi && svc_any;
        xfer   = req_any && (ack || retire);
        if (retire) begin
            st_d.svc[svc_top] = 1'b0;
        end
        if (xfer) begin
            st_d.req[req_top] = 1'b0;
            st_d.svc[req_top] = 1'b1;
        end
        if (acc_vld) begin
            st_d.req[acc_vec] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disp_vec = svc_top;
    assign irr_o    = st_q.req;
    assign isr_o    = st_q.svc;

    // R1: an accepted vector is pending next cycle
    a_r1_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> irr_o[$past(acc_vec)]);

    // R3: acknowledge moves the top request into service
    a_r3_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_any) |=> isr_o[$past(req_top)]);

    // R6: end-of-interrupt retires the top service bit
    a_r6_eoi_retires_top: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && svc_any && !(req_any && req_top == svc_top)) |=> !isr_o[$past(svc_top)]);

    // R9: end-of-interrupt with nothing in service leaves service set alone
    a_r9_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !svc_any && !ack) |=> $stable(isr_o));

    // R7: at most one new service bit per edge
    a_r7_one_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ($countones(isr_o) <= $countones($past(isr_o)) + 1));

    // R10: pending requires a waiting request
    a_r10_pend_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend |-> (irr_o != '0));
endmodule

// File: tb/vit_tracker_tb_top.sv
module vit_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 256;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           acc_vld = 1'b0;
    logic [7:0]     acc_vec = '0;
    logic           ack = 1'b0;
    logic           eoi = 1'b0;
    logic [7:0]     disp_vec;
    logic           int_pend;
    logic [NV-1:0]  irr_o, isr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit m_req [NV];
    bit m_svc [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    vit_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_vec(acc_vec),
        .ack(ack), .eoi(eoi), .disp_vec(disp_vec), .int_pend(int_pend),
        .irr_o(irr_o), .isr_o(isr_o)
    );

    function automatic int highest(input bit s [NV]);
        for (int i = NV - 1; i >= 0; i--) if (s[i]) return i;
        return -1;
    endfunction

    function automatic logic [NV-1:0] pack(input bit s [NV]);
        logic [NV-1:0] v = '0;
        for (int i = 0; i < NV; i++) v[i] = s[i];
        return v;
    endfunction

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        int hq, hs;
        logic [7:0] exp_disp;
        logic exp_pend;
        hq = highest(m_req);
        hs = highest(m_svc);
        exp_disp = (hs < 0) ? 8'd0 : 8'(hs);
        exp_pend = (hq >= 0) && ((hs < 0) || ((hq / 16) > (hs / 16)));
        checks++;
        if (irr_o !== pack(m_req)) begin
            errors++;
            $display("FAIL %s irr: got %h expected %h", tag, irr_o, pack(m_req));
        end
        checks++;
        if (isr_o !== pack(m_svc)) begin
            errors++;
            $display("FAIL %s isr: got %h expected %h", tag, isr_o, pack(m_svc));
        end
        checks++;
        if (disp_vec !== exp_disp) begin
            errors++;
            $display("FAIL %s R4 disp_vec: got %0d expected %0d", tag, disp_vec, exp_disp);
        end
        checks++;
        if (int_pend !== exp_pend) begin
            errors++;
            $display("FAIL %s R10 int_pend: got %0b expected %0b", tag, int_pend, exp_pend);
        end
    endtask

    task automatic step(input bit a, input int v, input bit k, input bit e, input string tag);
        int hq, hs;
        bit ret;
        acc_vld = a; acc_vec = 8'(v); ack = k; eoi = e;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) begin m_req[i] = 0; m_svc[i] = 0; end
        end else begin
            hq = highest(m_req);
            hs = highest(m_svc);
            ret = e && (hs >= 0);
            if (ret) m_svc[hs] = 0;
            if (hq >= 0 && (k || ret)) begin
                m_req[hq] = 0;
                m_svc[hq] = 1;
            end
            if (a) m_req[v] = 1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        step(0, 0, 0, 0, "R11 reset");
        step(1, 5, 1, 1, "R11 reset ignores inputs");
        rst_n = 1;

        // R1/R2: accept and merge
        step(1, 8'h30, 0, 0, "R1 accept 0x30");
        step(1, 8'h30, 0, 0, "R2 merge 0x30");
        step(1, 8'h02, 0, 0, "R1 accept 0x02");
        // R3: ack moves highest
        step(0, 0, 1, 0, "R3 ack top");
        // R10: same class request does not pend
        step(1, 8'h3A, 0, 0, "R10 same class");
        check_bit("R10 same class no pend", int_pend, 1'b0);
        step(1, 8'h40, 0, 0, "R10 higher class");
        check_bit("R10 higher class pend", int_pend, 1'b1);
        // R5: accept during service, with ack same cycle on same vector
        step(1, 8'h40, 1, 0, "R5 accept+ack same vector");
        check_bit("R5 0x40 in service", isr_o[8'h40], 1'b1);
        check_bit("R5 0x40 still pending", irr_o[8'h40], 1'b1);
        // R6/R7: eoi retires top and transfers
        step(0, 0, 0, 1, "R6 R7 eoi");
        // R7: ack and eoi together move one
        step(1, 8'h11, 1, 1, "R7 ack+eoi");
        // drain
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R6 drain");
        step(0, 0, 0, 1, "R9 eoi empty");
        step(0, 0, 1, 0, "R3 ack empty");

        // R8: surplus end-of-interrupt loses nested vector
        rst_n = 0; step(0, 0, 0, 0, "R11 reset again"); rst_n = 1;
        step(1, 8'h30, 0, 0, "R8 setup");
        step(0, 0, 1, 0, "R8 service 0x30");
        step(1, 8'h50, 0, 0, "R8 nested 0x50");
        step(1, 8'h60, 0, 0, "R8 nested 0x60");
        step(0, 0, 0, 1, "R8 first eoi");
        check_bit("R8 0x60 moved in", isr_o[8'h60], 1'b1);
        step(0, 0, 0, 1, "R8 surplus eoi");
        check_bit("R8 0x60 lost from service", isr_o[8'h60], 1'b0);
        check_bit("R8 0x60 lost from request", irr_o[8'h60], 1'b0);
        check_bit("R8 0x50 now in service", isr_o[8'h50], 1'b1);

        // R11: reset with state loaded
        rst_n = 0; step(1, 8'hFF, 1, 0, "R11 reset clears"); rst_n = 1;

        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            int r, v;
            r = int'($urandom % 16);
            v = (r < 8) ? int'($urandom % 8) * 16 + int'($urandom % 3) : int'($urandom % 256);
            step(($urandom % 3) != 0, v, ($urandom % 4) == 0, ($urandom % 4) == 0, "R5 mixed");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule